// File: doc/BRIEF.md
# Sleep and Idle power-mode controller

This block decides which clock domains of a small processor system are running. A power-save command with a one-bit mode operand puts the system into one of two low-power modes. Idle stops only the CPU clock; the main oscillator and all peripheral clocks keep running. Sleep shuts the main oscillator down and stops the CPU and every peripheral that depends on the system clock. Peripherals clocked from an external source keep their enables. The fail-safe clock monitor is switched off, and the low-power RC oscillator stays on only when the watchdog needs it.

The controller watches a vector of interrupt requests, each with its own enable bit, plus a watchdog time-out and a device reset request. Any of these brings the system back to Run. Before Sleep is entered with the watchdog enabled, the block pulses a watchdog clear. The system clock selection is frozen while a low-power mode is active, so the system resumes on the source it was using before entry. The oscillators, gating cells, watchdog counter and CPU are outside the block and are seen only through enable and request signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In Run, `ps_cmd_valid` with `ps_cmd_mode`=0 enters Sleep and with `ps_cmd_mode`=1 enters Idle on the next clock. `mode_status` reads 2'b00 in Run, 2'b01 in Idle and 2'b10 in Sleep. A command given while already in a low-power mode has no effect.
- R2: In Sleep, `cpu_clk_en` and `main_osc_en` are low.
- R3: In Idle, `cpu_clk_en` is low while `main_osc_en` and every bit of `periph_clk_en` are high.
- R4: In either low-power mode, a request bit i of `irq_req` with bit i of `irq_en` set, or `wdt_timeout`, returns the block to Run on the next clock. A request whose own enable bit is clear is ignored, even when other enable bits are set.
- R5: `wdt_clear` is high, combinationally, exactly in a Run cycle where a Sleep command is accepted and `wdt_enable` is high. It is low in every other cycle.
- R6: `lprc_en` equals `wdt_enable` in Sleep and is high in Run and Idle.
- R7: `fscm_en` is low in Sleep and high in Run and Idle.
- R8: A `clk_sw_req` in Run loads `clk_sw_sel` into `clk_sel_out` on the next clock. In Idle or Sleep the request is ignored, so after wake `clk_sel_out` still holds the value selected before entry.
- R9: `dev_rst_req` in Idle or Sleep returns to Run on the next clock and sets `rst_from_idle` or `rst_from_sleep` for the mode that was active, clearing the other flag. In Run it clears both flags and blocks any command in the same cycle.
- R10: A wake condition already present in the cycle of a power-save command cancels the entry, and the block stays in Run.
- R11: In Sleep, `periph_clk_en` equals `ext_clk_periph`. In Run every bit is high.
- R12: Asynchronous `rst_n` low gives Run, both reset flags low, `clk_sel_out` equal to `CLK_SEL_RST` (0 by default) and `wdt_clear` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ps_cmd_valid | input | 1 | Power-save command strobe |
| ps_cmd_mode | input | 1 | Command operand: 0 Sleep, 1 Idle |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_enable | input | 1 | Watchdog is enabled |
| dev_rst_req | input | 1 | Device reset request |
| clk_sw_req | input | 1 | Request to change the system clock source |
| clk_sw_sel | input | CLK_SEL_W | Requested clock source code |
| ext_clk_periph | input | N_PERIPH | Peripherals running from an external clock |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| wdt_clear | output | 1 | Watchdog clear pulse |
| mode_status | output | 2 | Current mode code |
| rst_from_sleep | output | 1 | Last device reset came during Sleep |
| rst_from_idle | output | 1 | Last device reset came during Idle |
| clk_sel_out | output | CLK_SEL_W | Active system clock source code |

## Verification
Every enable output is decoded from the registered mode. A wrong mode state therefore shows on `mode_status` and on the whole enable group in the first cycle after the edge that stored it. A clock selection that is lost or overwritten shows on `clk_sel_out` only after a wake, and that is where the sweeps compare it. The sweeps cover both modes against every interrupt line, with the line's enable set and cleared. They also cover every external-clock peripheral mask with the watchdog enabled and disabled. Flags corrupted by a device reset are visible on the two flag outputs one cycle after the request.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10
    } pm_state_e;

    localparam logic CMD_SLEEP = 1'b0;
    localparam logic CMD_IDLE  = 1'b1;

    typedef struct packed {
        pm_state_e state;
        logic      rst_sleep;
        logic      rst_idle;
    } pm_regs_t;

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             wake_any
);
    logic [N_IRQ-1:0] masked;

    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_line
        assign masked[gi] = irq_req[gi] & irq_en[gi];
    end

    always_comb begin
        wake_any = (|masked) | wdt_timeout;
    end
endmodule

// File: rtl/pwr_clk_sel_hold.sv
module pwr_clk_sel_hold #(
    parameter int                 CLK_SEL_W   = 3,
    parameter logic [CLK_SEL_W-1:0] CLK_SEL_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_ok,
    input  logic                 sw_req,
    input  logic [CLK_SEL_W-1:0] sw_sel,
    output logic [CLK_SEL_W-1:0] sel_out
);
    logic [CLK_SEL_W-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (load_ok && sw_req) begin
            sel_d = sw_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= CLK_SEL_RST;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_out = sel_q;
endmodule

// File: rtl/pwr_clk_en_decode.sv
module pwr_clk_en_decode
    import pwr_mode_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  pm_state_e           state,
    input  logic                wdt_enable,
    input  logic [N_PERIPH-1:0] ext_clk_periph,
    output logic                cpu_clk_en,
    output logic                main_osc_en,
    output logic                fscm_en,
    output logic                lprc_en,
    output logic [N_PERIPH-1:0] periph_clk_en
);
    logic in_sleep;
    logic in_run;

    always_comb begin
        in_sleep    = (state == PM_SLEEP);
        in_run      = (state == PM_RUN);
        cpu_clk_en  = in_run;
        main_osc_en = !in_sleep;
        fscm_en     = !in_sleep;
        lprc_en     = in_sleep ? wdt_enable : 1'b1;
    end

    for (genvar gp = 0; gp < N_PERIPH; gp++) begin : g_periph
        assign periph_clk_en[gp] = !in_sleep | ext_clk_periph[gp];
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int                   N_IRQ       = 8,
    parameter int                   N_PERIPH    = 4,
    parameter int                   CLK_SEL_W   = 3,
    parameter logic [CLK_SEL_W-1:0] CLK_SEL_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ps_cmd_valid,
    input  logic                 ps_cmd_mode,
    input  logic [N_IRQ-1:0]     irq_req,
    input  logic [N_IRQ-1:0]     irq_en,
    input  logic                 wdt_timeout,
    input  logic                 wdt_enable,
    input  logic                 dev_rst_req,
    input  logic                 clk_sw_req,
    input  logic [CLK_SEL_W-1:0] clk_sw_sel,
    input  logic [N_PERIPH-1:0]  ext_clk_periph,
    output logic                 cpu_clk_en,
    output logic [N_PERIPH-1:0]  periph_clk_en,
    output logic                 main_osc_en,
    output logic                 fscm_en,
    output logic                 lprc_en,
    output logic                 wdt_clear,
    output logic [1:0]           mode_status,
    output logic                 rst_from_sleep,
    output logic                 rst_from_idle,
    output logic [CLK_SEL_W-1:0] clk_sel_out
);
    pm_regs_t regs_d, regs_q;
    logic     wake_any;
    logic     enter_ok;

    pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .wake_any    (wake_any)
    );

    // Entry is accepted only in Run with no wake or reset pending.
    always_comb begin
        enter_ok = (regs_q.state == PM_RUN) && ps_cmd_valid
                   && !wake_any && !dev_rst_req;
    end

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            PM_RUN: begin
                if (dev_rst_req) begin
                    regs_d.rst_sleep = 1'b0;
                    regs_d.rst_idle  = 1'b0;
                end else if (enter_ok) begin
                    regs_d.state = (ps_cmd_mode == CMD_IDLE) ? PM_IDLE : PM_SLEEP;
                end
            end
            PM_IDLE, PM_SLEEP: begin
                if (dev_rst_req) begin
                    regs_d.state     = PM_RUN;
                    regs_d.rst_sleep = (regs_q.state == PM_SLEEP);
                    regs_d.rst_idle  = (regs_q.state == PM_IDLE);
                end else if (wake_any) begin
                    regs_d.state = PM_RUN;
                end
            end
            default: regs_d.state = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: PM_RUN, rst_sleep: 1'b0, rst_idle: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        wdt_clear = enter_ok && (ps_cmd_mode == CMD_SLEEP) && wdt_enable;
    end

    pwr_clk_sel_hold #(
        .CLK_SEL_W   (CLK_SEL_W),
        .CLK_SEL_RST (CLK_SEL_RST)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_ok (regs_q.state == PM_RUN),
        .sw_req  (clk_sw_req),
        .sw_sel  (clk_sw_sel),
        .sel_out (clk_sel_out)
    );

    pwr_clk_en_decode #(.N_PERIPH(N_PERIPH)) u_dec (
        .state          (regs_q.state),
        .wdt_enable     (wdt_enable),
        .ext_clk_periph (ext_clk_periph),
        .cpu_clk_en     (cpu_clk_en),
        .main_osc_en    (main_osc_en),
        .fscm_en        (fscm_en),
        .lprc_en        (lprc_en),
        .periph_clk_en  (periph_clk_en)
    );

    assign mode_status    = regs_q.state;
    assign rst_from_sleep = regs_q.rst_sleep;
    assign rst_from_idle  = regs_q.rst_idle;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int N_IRQ     = 8,
    parameter int N_PERIPH  = 4,
    parameter int CLK_SEL_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ps_cmd_valid,
    input logic                 ps_cmd_mode,
    input logic [N_IRQ-1:0]     irq_req,
    input logic [N_IRQ-1:0]     irq_en,
    input logic                 wdt_timeout,
    input logic                 wdt_enable,
    input logic                 dev_rst_req,
    input logic [N_PERIPH-1:0]  ext_clk_periph,
    input logic                 cpu_clk_en,
    input logic [N_PERIPH-1:0]  periph_clk_en,
    input logic                 main_osc_en,
    input logic                 fscm_en,
    input logic                 lprc_en,
    input logic                 wdt_clear,
    input logic [1:0]           mode_status,
    input logic                 rst_from_sleep,
    input logic                 rst_from_idle,
    input logic [CLK_SEL_W-1:0] clk_sel_out
);
    logic wake_seen;
    assign wake_seen = (|(irq_req & irq_en)) | wdt_timeout;

    p_status_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status != 2'b11);

    p_cmd_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01 && !wake_seen && !dev_rst_req) |=> mode_status == 2'b01);

    p_sleep_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10) |-> (!cpu_clk_en && !main_osc_en));

    p_idle_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01) |-> (!cpu_clk_en && main_osc_en && (&periph_clk_en)));

    p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status != 2'b00 && wake_seen) |=> mode_status == 2'b00);

    p_wdt_clr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |-> (mode_status == 2'b00 && ps_cmd_valid && !ps_cmd_mode && wdt_enable));

    p_wdt_clr_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> mode_status == 2'b10);

    p_lprc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10) |-> (lprc_en == wdt_enable));

    p_fscm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fscm_en == (mode_status != 2'b10));

    p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status != 2'b00) |=> $stable(clk_sel_out));

    p_rst_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10 && dev_rst_req) |=> (mode_status == 2'b00 && rst_from_sleep && !rst_from_idle));

    p_rst_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_from_sleep && rst_from_idle));

    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b00 && ps_cmd_valid && wake_seen) |=> mode_status == 2'b00);

    p_ext_periph_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10) |-> (periph_clk_en == ext_clk_periph));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
    .N_IRQ     (N_IRQ),
    .N_PERIPH  (N_PERIPH),
    .CLK_SEL_W (CLK_SEL_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ps_cmd_valid   (ps_cmd_valid),
    .ps_cmd_mode    (ps_cmd_mode),
    .irq_req        (irq_req),
    .irq_en         (irq_en),
    .wdt_timeout    (wdt_timeout),
    .wdt_enable     (wdt_enable),
    .dev_rst_req    (dev_rst_req),
    .ext_clk_periph (ext_clk_periph),
    .cpu_clk_en     (cpu_clk_en),
    .periph_clk_en  (periph_clk_en),
    .main_osc_en    (main_osc_en),
    .fscm_en        (fscm_en),
    .lprc_en        (lprc_en),
    .wdt_clear      (wdt_clear),
    .mode_status    (mode_status),
    .rst_from_sleep (rst_from_sleep),
    .rst_from_idle  (rst_from_idle),
    .clk_sel_out    (clk_sel_out)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NP = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ps_cmd_valid = 1'b0;
    logic          ps_cmd_mode = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic          wdt_timeout = 1'b0;
    logic          wdt_enable = 1'b0;
    logic          dev_rst_req = 1'b0;
    logic          clk_sw_req = 1'b0;
    logic [SW-1:0] clk_sw_sel = '0;
    logic [NP-1:0] ext_clk_periph = '0;
    logic          cpu_clk_en;
    logic [NP-1:0] periph_clk_en;
    logic          main_osc_en;
    logic          fscm_en;
    logic          lprc_en;
    logic          wdt_clear;
    logic [1:0]    mode_status;
    logic          rst_from_sleep;
    logic          rst_from_idle;
    logic [SW-1:0] clk_sel_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .N_PERIPH(NP), .CLK_SEL_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ps_cmd_valid(ps_cmd_valid), .ps_cmd_mode(ps_cmd_mode),
        .irq_req(irq_req), .irq_en(irq_en), .wdt_timeout(wdt_timeout), .wdt_enable(wdt_enable),
        .dev_rst_req(dev_rst_req), .clk_sw_req(clk_sw_req), .clk_sw_sel(clk_sw_sel),
        .ext_clk_periph(ext_clk_periph), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .main_osc_en(main_osc_en), .fscm_en(fscm_en), .lprc_en(lprc_en), .wdt_clear(wdt_clear),
        .mode_status(mode_status), .rst_from_sleep(rst_from_sleep), .rst_from_idle(rst_from_idle),
        .clk_sel_out(clk_sel_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Command at a negedge; wdt_clear checked in the command cycle.
    task automatic send_cmd(input logic mode, input logic exp_clr);
        ps_cmd_valid = 1'b1;
        ps_cmd_mode  = mode;
        #1;
        chk("R5 wdt_clear in command cycle", 32'(wdt_clear), 32'(exp_clr));
        step();
        ps_cmd_valid = 1'b0;
    endtask

    task automatic wake_by_wdt();
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("R4 watchdog wake to Run", 32'(mode_status), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R12 reset state
        chk("R12 mode after reset", 32'(mode_status), 32'd0);
        chk("R12 flags after reset", {30'd0, rst_from_sleep, rst_from_idle}, 32'd0);
        chk("R12 clk_sel after reset", 32'(clk_sel_out), 32'd0);
        chk("R12 enables after reset", {cpu_clk_en, main_osc_en, fscm_en, lprc_en, wdt_clear, periph_clk_en},
            {5'b11110, 4'hF});
        rst_n = 1'b1;
        step();

        // R1 R2 R3 R6 R7 R11 sweep over mode, watchdog enable and peripheral mask
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int mk = 0; mk < (1 << NP); mk++) begin
                    logic sl;
                    sl = (m == 0);
                    wdt_enable = w[0];
                    ext_clk_periph = mk[NP-1:0];
                    chk("R11 periph all on in Run", 32'(periph_clk_en), 32'hF);
                    send_cmd(m[0], sl && w[0]);
                    chk("R1 mode code after command", 32'(mode_status), sl ? 32'd2 : 32'd1);
                    chk("R2 R3 cpu_clk_en off", 32'(cpu_clk_en), 32'd0);
                    chk("R2 R3 main_osc_en", 32'(main_osc_en), 32'(!sl));
                    chk("R7 fscm_en", 32'(fscm_en), 32'(!sl));
                    chk("R6 lprc_en", 32'(lprc_en), sl ? 32'(w) : 32'd1);
                    chk("R3 R11 periph enables", 32'(periph_clk_en), sl ? 32'(mk) : 32'hF);
                    send_cmd(~m[0], 1'b0);
                    chk("R1 command ignored in low-power mode", 32'(mode_status), sl ? 32'd2 : 32'd1);
                    wake_by_wdt();
                    chk("R2 cpu back on after wake", 32'(cpu_clk_en), 32'd1);
                end
            end
        end
        wdt_enable = 1'b0;
        ext_clk_periph = '0;

        // R4 sweep: every interrupt line with its own enable set or clear
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < NI; i++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [NI-1:0] bit_i;
                    bit_i = NI'(1) << i;
                    send_cmd(m[0], 1'b0);
                    irq_req = bit_i;
                    irq_en  = (e == 1) ? bit_i : ~bit_i;
                    step();
                    irq_req = '0;
                    irq_en  = '0;
                    chk("R4 interrupt wake gated by own enable", 32'(mode_status),
                        (e == 1) ? 32'd0 : ((m == 0) ? 32'd2 : 32'd1));
                    if (e == 0) wake_by_wdt();
                end
            end
        end

        // R10 cancel by pending interrupt or time-out
        for (int m = 0; m < 2; m++) begin
            wdt_enable = 1'b1;
            irq_req = 8'h10; irq_en = 8'h10;
            send_cmd(m[0], 1'b0);
            chk("R10 pending irq cancels entry", 32'(mode_status), 32'd0);
            irq_req = '0; irq_en = '0;
            wdt_timeout = 1'b1;
            send_cmd(m[0], 1'b0);
            wdt_timeout = 1'b0;
            chk("R10 pending time-out cancels entry", 32'(mode_status), 32'd0);
        end
        wdt_enable = 1'b0;

        // R8 clock source hold
        clk_sw_req = 1'b1; clk_sw_sel = 3'd5;
        step();
        clk_sw_req = 1'b0;
        chk("R8 switch in Run", 32'(clk_sel_out), 32'd5);
        for (int m = 0; m < 2; m++) begin
            send_cmd(m[0], 1'b0);
            clk_sw_req = 1'b1; clk_sw_sel = 3'(2 + m);
            step();
            clk_sw_req = 1'b0;
            chk("R8 switch ignored in low-power mode", 32'(clk_sel_out), 32'd5);
            wake_by_wdt();
            chk("R8 source restored after wake", 32'(clk_sel_out), 32'd5);
        end

        // R9 device reset
        send_cmd(1'b0, 1'b0);
        dev_rst_req = 1'b1; irq_req = 8'h01; irq_en = 8'h01;
        step();
        dev_rst_req = 1'b0; irq_req = '0; irq_en = '0;
        chk("R9 reset from Sleep to Run", 32'(mode_status), 32'd0);
        chk("R9 flags after Sleep reset", {30'd0, rst_from_sleep, rst_from_idle}, 32'b10);
        send_cmd(1'b1, 1'b0);
        dev_rst_req = 1'b1;
        step();
        dev_rst_req = 1'b0;
        chk("R9 flags after Idle reset", {30'd0, rst_from_sleep, rst_from_idle}, 32'b01);
        dev_rst_req = 1'b1; wdt_enable = 1'b1;
        ps_cmd_valid = 1'b1; ps_cmd_mode = 1'b0;
        #1;
        chk("R5 no clear when reset blocks entry", 32'(wdt_clear), 32'd0);
        step();
        ps_cmd_valid = 1'b0; dev_rst_req = 1'b0; wdt_enable = 1'b0;
        chk("R9 reset in Run blocks command", 32'(mode_status), 32'd0);
        chk("R9 reset in Run clears flags", {30'd0, rst_from_sleep, rst_from_idle}, 32'd0);

        // R12 asynchronous reset while sleeping
        send_cmd(1'b0, 1'b0);
        #2 rst_n = 1'b0;
        #1;
        chk("R12 async reset to Run", 32'(mode_status), 32'd0);
        chk("R12 clk_sel reset", 32'(clk_sel_out), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule